// File: doc/BRIEF.md
# Program Memory Boot Loader

This block fills a program memory of 48-bit words straight out of reset, before the processor starts fetching. A two-bit strap, captured in the final clock cycle of reset, picks one of four boot sources: no load at all, an 8-bit parallel port, a 16-bit parallel port, or a 16-bit synchronous serial input. Incoming bytes are packed into a 48-bit holding register least significant byte first. The first complete word is a header, and the low 20 bits of that header give the number of program words that follow. Each later word becomes one write towards program memory, with an optional even parity bit.

Both input sources and the program-memory write port use valid/ready. A unit of input moves on any rising edge where its valid and ready are both high. An unselected source sees ready held low. The input ready also drops while a complete word waits to be consumed. On the write side, valid, address, data and parity stay steady until ready is seen, so the memory side can stall the loader for any number of cycles. When the counted words are all written, the done output rises and stays high. A separate software-written flag drives the system-available pin.

Top module: `pm_boot_loader`

## Requirements
- R1: The source code on `strap_i` (00 none, 01 8-bit parallel, 10 16-bit parallel, 11 serial) is captured on the last rising edge with `rst_n` low. Later changes of `strap_i` have no effect until the next reset.
- R2: With source 00, `done_o` is high from the first cycle after reset, both input readies stay low and no write is issued.
- R3: In 8-bit parallel mode, each transfer on the parallel port carries one byte on `pbus_data_i[15:8]`. The other bus bits are ignored, and bytes fill each 48-bit word from bits 7..0 upwards to bits 47..40.
- R4: In 16-bit parallel mode, each transfer carries two bytes on `pbus_data_i[23:8]`, with bits 15..8 as the earlier byte. Three transfers make one word.
- R5: In serial mode, each transfer on the serial port carries two bytes on `ser_data_i`, with bits 7..0 as the earlier byte. The parallel port is ignored, and in the parallel modes the serial port is ignored.
- R6: The first assembled word is a header whose bits 19..0 give the word count. Its other bits are ignored, and the header itself is never written.
- R7: Program words are written at addresses 0, 1, 2 and so on, one address per word, with data equal to the assembled word.
- R8: When `par_en_i` is 1, `pm_wr_par_o` makes the number of ones across data and parity even. When `par_en_i` is 0, `pm_wr_par_o` is 0.
- R9: `done_o` rises after the write of the last counted word is accepted. A count of zero gives done directly after the header, with no writes.
- R10: While `pm_wr_valid_o` is high and `pm_wr_ready_i` low, address, data and parity hold steady. No new input is accepted while a complete word is pending.
- R11: `sys_avail_o` takes the value of `cfg_sysav_i` on the cycle after a cycle with `cfg_wr_i` high. It is 0 after reset.
- R12: Once `done_o` is high it stays high, both input readies are low and no further write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | 2 | Boot source strap |
| par_en_i | input | 1 | Enables parity generation |
| pbus_data_i | input | DBUS_W | Parallel data bus |
| pbus_valid_i | input | 1 | Parallel transfer valid |
| pbus_ready_o | output | 1 | Parallel transfer ready |
| ser_data_i | input | 16 | Deserialized halfword |
| ser_valid_i | input | 1 | Serial halfword valid |
| ser_ready_o | output | 1 | Serial halfword ready |
| pm_wr_valid_o | output | 1 | Program-memory write valid |
| pm_wr_ready_i | input | 1 | Program-memory write ready |
| pm_wr_addr_o | output | CNT_W | Write address |
| pm_wr_data_o | output | 48 | Write data |
| pm_wr_par_o | output | 1 | Write parity bit |
| done_o | output | 1 | Load complete |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sysav_i | input | 1 | System-available value to write |
| sys_avail_o | output | 1 | System-available pin |

## Verification
The assertions check the following on every cycle: write stability under stall, address stepping by one per accepted write, even parity across data and parity bit, the source choice staying fixed after reset, no byte arriving into a full holding register, and done being sticky and silent. Byte order, the header's 20-bit count with its garbage upper bits, the choice of bus lanes, and ignoring the unselected port can only be shown by the bench. It sweeps every source, counts 0 to 3 and both parity settings, and compares each written word with values computed arithmetically from the stream it sent.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_P8   = 2'b01,
    SRC_P16  = 2'b10,
    SRC_SER  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    ST_HDR  = 2'b00,
    ST_LOAD = 2'b01,
    ST_DONE = 2'b10
  } st_e;
endpackage

// File: rtl/pmb_strap.sv
module pmb_strap
  import pmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_i,
  output src_e       src_o
);
  src_e src_q;

  // Captured on every reset edge; the last one wins.
  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= src_e'(strap_i);
  end

  assign src_o = src_q;

  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(src_q)); // R1
endmodule

// File: rtl/pmb_src_mux.sv
module pmb_src_mux
  import pmb_pkg::*;
#(
  parameter int DBUS_W = 40
) (
  input  src_e              src_i,
  input  logic              take_en_i,
  input  logic [DBUS_W-1:0] pbus_data_i,
  input  logic              pbus_valid_i,
  output logic              pbus_ready_o,
  input  logic [15:0]       ser_data_i,
  input  logic              ser_valid_i,
  output logic              ser_ready_o,
  output logic              unit_valid_o,
  output logic [15:0]       unit_data_o,
  output logic              unit_two_o
);
  logic unused_bits;
  assign unused_bits = ^{pbus_data_i[DBUS_W-1:24], pbus_data_i[7:0]};

  always_comb begin
    pbus_ready_o = 1'b0;
    ser_ready_o  = 1'b0;
    unit_valid_o = 1'b0;
    unit_data_o  = '0;
    unit_two_o   = 1'b0;
    unique case (src_i)
      SRC_P8: begin
        pbus_ready_o = take_en_i;
        unit_valid_o = pbus_valid_i;
        unit_data_o  = {8'h00, pbus_data_i[15:8]};
      end
      SRC_P16: begin
        pbus_ready_o = take_en_i;
        unit_valid_o = pbus_valid_i;
        unit_data_o  = pbus_data_i[23:8];
        unit_two_o   = 1'b1;
      end
      SRC_SER: begin
        ser_ready_o  = take_en_i;
        unit_valid_o = ser_valid_i;
        unit_data_o  = ser_data_i;
        unit_two_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmb_packer.sv
module pmb_packer #(
  parameter int WORD_BYTES = 6,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int BCNT_W = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [15:0]       data_i,
  input  logic              two_i,
  input  logic              clear_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o
);
  logic [BCNT_W-1:0] bcnt_q;
  logic [BCNT_W-1:0] bcnt_nx;
  logic              full_q;

  assign bcnt_nx = bcnt_q + (two_i ? BCNT_W'(2) : BCNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      bcnt_q <= '0;
      full_q <= 1'b0;
    end else if (take_i) begin
      bcnt_q <= bcnt_nx;
      full_q <= (bcnt_nx == BCNT_W'(WORD_BYTES));
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (take_i && bcnt_q == BCNT_W'(g)) begin
        lane_q <= data_i[7:0];
      end else if (take_i && two_i && (bcnt_q + BCNT_W'(1)) == BCNT_W'(g)) begin
        lane_q <= data_i[15:8];
      end
    end
    assign word_o[g*8 +: 8] = lane_q;
  end

  assign full_o = full_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !full_q); // R10
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && two_i) |-> !bcnt_q[0]); // R4
endmodule

// File: rtl/pmb_parity.sv
module pmb_parity #(
  parameter int W   = 48,
  parameter bit ODD = 1'b0
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic         par_o
);
  if (ODD) begin : g_odd
    assign par_o = en_i & ~(^data_i);
  end else begin : g_even
    assign par_o = en_i & (^data_i);
  end
endmodule

// File: rtl/pm_boot_loader.sv
module pm_boot_loader
  import pmb_pkg::*;
#(
  parameter int DBUS_W     = 40,
  parameter int CNT_W      = 20,
  parameter int WORD_BYTES = 6,
  localparam int WORD_W    = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  input  logic              par_en_i,
  input  logic [DBUS_W-1:0] pbus_data_i,
  input  logic              pbus_valid_i,
  output logic              pbus_ready_o,
  input  logic [15:0]       ser_data_i,
  input  logic              ser_valid_i,
  output logic              ser_ready_o,
  output logic              pm_wr_valid_o,
  input  logic              pm_wr_ready_i,
  output logic [CNT_W-1:0]  pm_wr_addr_o,
  output logic [WORD_W-1:0] pm_wr_data_o,
  output logic              pm_wr_par_o,
  output logic              done_o,
  input  logic              cfg_wr_i,
  input  logic              cfg_sysav_i,
  output logic              sys_avail_o
);
  src_e              src;
  st_e               st_q;
  logic              take_en, unit_valid, unit_two, take, full, clear;
  logic [15:0]       unit_data;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt_q, addr_q;
  logic              sysav_q, wr_fire;

  pmb_strap u_strap (.clk(clk), .rst_n(rst_n), .strap_i(strap_i), .src_o(src));

  pmb_src_mux #(.DBUS_W(DBUS_W)) u_mux (
    .src_i(src), .take_en_i(take_en),
    .pbus_data_i(pbus_data_i), .pbus_valid_i(pbus_valid_i), .pbus_ready_o(pbus_ready_o),
    .ser_data_i(ser_data_i), .ser_valid_i(ser_valid_i), .ser_ready_o(ser_ready_o),
    .unit_valid_o(unit_valid), .unit_data_o(unit_data), .unit_two_o(unit_two)
  );

  pmb_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .take_i(take), .data_i(unit_data), .two_i(unit_two),
    .clear_i(clear), .full_o(full), .word_o(word)
  );

  pmb_parity #(.W(WORD_W), .ODD(1'b0)) u_par (
    .data_i(word), .en_i(par_en_i), .par_o(pm_wr_par_o)
  );

  assign take_en       = (st_q != ST_DONE) && !full;
  assign take          = take_en && unit_valid;
  assign pm_wr_valid_o = (st_q == ST_LOAD) && full;
  assign wr_fire       = pm_wr_valid_o && pm_wr_ready_i;
  assign clear         = ((st_q == ST_HDR) && full) || wr_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= (strap_i == 2'b00) ? ST_DONE : ST_HDR;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_HDR: if (full) begin
          cnt_q <= word[CNT_W-1:0];
          st_q  <= (word[CNT_W-1:0] == '0) ? ST_DONE : ST_LOAD;
        end
        ST_LOAD: if (wr_fire) begin
          addr_q <= addr_q + CNT_W'(1);
          if (addr_q == cnt_q - CNT_W'(1)) st_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sysav_q <= 1'b0;
    else if (cfg_wr_i) sysav_q <= cfg_sysav_i;
  end

  assign pm_wr_addr_o = addr_q;
  assign pm_wr_data_o = word;
  assign done_o       = (st_q == ST_DONE);
  assign sys_avail_o  = sysav_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_wr_valid_o && !pm_wr_ready_i) |=> (pm_wr_valid_o && $stable(pm_wr_data_o)
      && $stable(pm_wr_addr_o) && $stable(pm_wr_par_o))); // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (pm_wr_addr_o == $past(pm_wr_addr_o) + CNT_W'(1))); // R7
  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_wr_valid_o && par_en_i) |-> ($countones({pm_wr_data_o, pm_wr_par_o}) % 2 == 0)); // R8
  AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en_i |-> !pm_wr_par_o); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o); // R12
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pm_wr_valid_o && !pbus_ready_o && !ser_ready_o)); // R12
  AST_SRC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pbus_ready_o && ser_ready_o)); // R5
  AST_SYSAV: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> (sys_avail_o == $past(cfg_sysav_i))); // R11
endmodule

// File: tb/pm_boot_loader_bench.sv
module pm_boot_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap = 2'b00;
  logic        par_en = 1'b0;
  logic [39:0] pbus_data = '0;
  logic        pbus_valid = 1'b0;
  logic        pbus_ready;
  logic [15:0] ser_data = '0;
  logic        ser_valid = 1'b0;
  logic        ser_ready;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [19:0] wr_addr;
  logic [47:0] wr_data;
  logic        wr_par;
  logic        done;
  logic        cfg_wr = 1'b0;
  logic        cfg_sysav = 1'b0;
  logic        sys_avail;

  int n_chk = 0;
  int n_fail = 0;
  int stall_ctr = 0;

  always #4 clk = ~clk;

  pm_boot_loader u_pm_boot_loader (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .par_en_i(par_en),
    .pbus_data_i(pbus_data), .pbus_valid_i(pbus_valid), .pbus_ready_o(pbus_ready),
    .ser_data_i(ser_data), .ser_valid_i(ser_valid), .ser_ready_o(ser_ready),
    .pm_wr_valid_o(wr_valid), .pm_wr_ready_i(wr_ready), .pm_wr_addr_o(wr_addr),
    .pm_wr_data_o(wr_data), .pm_wr_par_o(wr_par), .done_o(done),
    .cfg_wr_i(cfg_wr), .cfg_sysav_i(cfg_sysav), .sys_avail_o(sys_avail)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_word(int m, int k);
    return 48'h0123_4567_89AB ^ (48'(k + 1) * 48'h0001_0203_0405) ^ (48'(m) << 40);
  endfunction

  function automatic logic [7:0] get_byte(int m, int cnt, int i);
    logic [47:0] w;
    int wi = i / 6;
    w = (wi == 0) ? {28'hFEDCBA9, 20'(cnt)} : exp_word(m, wi - 1);
    return w[(i % 6) * 8 +: 8];
  endfunction

  task automatic do_reset(int m);
    @(negedge clk);
    rst_n = 1'b0;
    strap = ~2'(m);
    repeat (3) @(negedge clk);
    strap = 2'(m);
    @(negedge clk);
    rst_n = 1'b1;
    strap = ~2'(m);  // R1: later strap values must not matter
  endtask

  task automatic produce(int m, int cnt);
    int nb = (m == 1) ? 1 : 2;
    int total = 6 * (cnt + 1);
    for (int i = 0; i < total; i += nb) begin
      if (m == 3) begin
        ser_valid  = 1'b1;
        ser_data   = {get_byte(m, cnt, i + 1), get_byte(m, cnt, i)};
        pbus_valid = 1'b1;
        pbus_data  = 40'hEE_DD_CC_BB_AA;  // R5: ignored port
      end else begin
        pbus_valid = 1'b1;
        ser_valid  = 1'b1;
        ser_data   = 16'hBEEF;            // R5: ignored port
        if (m == 1) pbus_data = {24'hC3C3C3, get_byte(m, cnt, i), 8'h3C};
        else pbus_data = {16'h9696, get_byte(m, cnt, i + 1), get_byte(m, cnt, i), 8'h69};
      end
      while (!((m == 3) ? ser_ready : pbus_ready)) @(negedge clk);
      @(negedge clk);
    end
    pbus_valid = 1'b0;
    ser_valid  = 1'b0;
  endtask

  task automatic consume(int m, int cnt, bit pe);
    int k = 0;
    bit held = 1'b0;
    logic [47:0] hd;
    logic [19:0] ha;
    while (k < cnt) begin
      @(negedge clk);
      if (held && wr_valid) begin
        chk(wr_data == hd && wr_addr == ha, "R10 stall hold", {wr_addr, wr_data[43:0]}, {ha, hd[43:0]});
      end
      stall_ctr++;
      wr_ready = (stall_ctr % 3) != 1;
      held = wr_valid && !wr_ready;
      hd = wr_data;
      ha = wr_addr;
      if (wr_valid && wr_ready) begin
        logic [47:0] e = exp_word(m, k);
        chk(wr_addr == 20'(k), "R7 address", 64'(wr_addr), 64'(k));
        chk(wr_data == e, (m == 1) ? "R3 data" : (m == 2) ? "R4 data" : "R5 data",
            64'(wr_data), 64'(e));
        chk(wr_par == (pe ? ^e : 1'b0), "R8 parity", 64'(wr_par), 64'(pe ? ^e : 1'b0));
        k++;
      end
    end
    @(negedge clk);
    wr_ready = 1'b0;
  endtask

  task automatic run_load(int m, int cnt, bit pe);
    int extra = 0;
    par_en = pe;
    do_reset(m);
    chk(done == 1'b0, "R1 not done after reset", 64'(done), 64'd0);
    fork
      produce(m, cnt);
      consume(m, cnt, pe);
    join
    repeat (3) @(negedge clk);
    chk(done == 1'b1, (cnt == 0) ? "R9 zero count done" : "R9 done", 64'(done), 64'd1);
    chk(wr_addr == 20'(cnt), "R6 header not written", 64'(wr_addr), 64'(cnt));
    pbus_valid = 1'b1;
    ser_valid  = 1'b1;
    wr_ready   = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (wr_valid || pbus_ready || ser_ready || !done) extra++;
    end
    chk(extra == 0, "R12 quiet after done", 64'(extra), 64'd0);
    pbus_valid = 1'b0;
    ser_valid  = 1'b0;
    wr_ready   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    do_reset(0);
    @(negedge clk);
    chk(done == 1'b1, "R2 no-load done", 64'(done), 64'd1);
    chk(sys_avail == 1'b0, "R11 reset value", 64'(sys_avail), 64'd0);
    pbus_valid = 1'b1;
    ser_valid  = 1'b1;
    wr_ready   = 1'b1;
    bad = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (pbus_ready || ser_ready || wr_valid) bad++;
    end
    chk(bad == 0, "R2 no-load quiet", 64'(bad), 64'd0);
    pbus_valid = 1'b0;
    ser_valid  = 1'b0;
    wr_ready   = 1'b0;

    cfg_wr = 1'b1; cfg_sysav = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sysav = 1'b0;
    chk(sys_avail == 1'b1, "R11 set", 64'(sys_avail), 64'd1);
    @(negedge clk);
    chk(sys_avail == 1'b1, "R11 hold", 64'(sys_avail), 64'd1);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(sys_avail == 1'b0, "R11 clear", 64'(sys_avail), 64'd0);

    for (int m = 1; m <= 3; m++)
      for (int cnt = 0; cnt <= 3; cnt++)
        for (int pe = 0; pe <= 1; pe++)
          run_load(m, cnt, 1'(pe));

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule